// File: doc/BRIEF.md
# Sign-Magnitude Magnitude Comparator

This block orders two operands held in sign-magnitude form. Each operand has a magnitude field plus a separate sign flag. The block drives exactly one of three combinational outputs: operand A greater than B, equal to B, or less than B. It is meant for datapaths that keep values as sign and magnitude, such as sensor readings or decimal-style arithmetic. Two's-complement operands are not handled.

The magnitude is cut into equal nibble slices. Each slice reaches its own greater, equal and less verdict. A merge stage then joins these verdicts, with the more significant slice taking precedence. A final sign stage turns the magnitude verdict into a signed ordering. The sign stage also treats a negative zero as the same value as a positive zero. With the defaults, there are 8 magnitude bits in two 4-bit slices.

Top module: `sm_compare`

## Requirements
- R1: Within a slice, the highest bit position at which the two operands differ decides the order. Lower bits matter only when all higher bits agree. For example, magnitudes 0x08 and 0x07 give greater for A.
- R2: With both signs positive, greater is asserted when the high slice of A exceeds that of B, or when the high slices match and the low slice of A exceeds that of B. For example, 0x80 against 0x7F gives greater.
- R3: With equal signs, equal is asserted only when every slice of the two magnitudes matches. For example, 0x35 against 0x35 gives equal, and 0x35 against 0x25 does not.
- R4: With both signs positive, less is asserted when the high slice of A is below that of B, or when the high slices match and the low slice of A is below that of B. For example, 0x34 against 0x35 gives less.
- R5: The sign flag encodes the sign: 0 is positive and 1 is negative. When the effective signs differ, the positive operand is the greater.
- R6: When both operands are positive, the outputs follow the ordering of the magnitudes.
- R7: When both operands are negative and neither magnitude is zero, the magnitude ordering is reversed. A larger magnitude is then the smaller value.
- R8: A zero magnitude counts as positive whatever its sign flag. So +0 and -0 compare as equal, and -0 is greater than any negative nonzero value.
- R9: For every input combination, exactly one of the three outputs is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_mag | input | MAG_W | Magnitude of operand A |
| a_neg | input | 1 | Sign flag of A (1 = negative) |
| b_mag | input | MAG_W | Magnitude of operand B |
| b_neg | input | 1 | Sign flag of B (1 = negative) |
| a_gt_b | output | 1 | A is greater than B |
| a_eq_b | output | 1 | A equals B |
| a_lt_b | output | 1 | A is less than B |

## Verification
The assertions are immediate checks on purely combinational paths. They assume that all four inputs carry known values, so each check is skipped while any input is X or Z. The stimulus drives every input from time zero and holds each vector steady before sampling. The sweep covers every magnitude pair under all four sign combinations, so every input stays a defined 0 or 1 throughout.

// File: rtl/sm_compare_pkg.sv
package sm_compare_pkg;

   typedef struct packed {
      logic gt;
      logic eq;
      logic lt;
   } ord_t;

   localparam ord_t ORD_EQ = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

   // Join a more significant verdict with a less significant one.
   function automatic ord_t ord_join(input ord_t upper, input ord_t lower);
      ord_t r;
      r.gt = upper.gt | (upper.eq & lower.gt);
      r.eq = upper.eq & lower.eq;
      r.lt = upper.lt | (upper.eq & lower.lt);
      return r;
   endfunction

   // Swap the greater and less flags.
   function automatic ord_t ord_flip(input ord_t v);
      ord_t r;
      r.gt = v.lt;
      r.eq = v.eq;
      r.lt = v.gt;
      return r;
   endfunction

endpackage

// File: rtl/mag_slice_cmp.sv
module mag_slice_cmp
   import sm_compare_pkg::*;
#(
   parameter int SLICE_W = 4
) (
   input  logic [SLICE_W-1:0] a_part,
   input  logic [SLICE_W-1:0] b_part,
   output ord_t               verdict
);

   generate
      if (SLICE_W < 1) begin : g_bad_width
         $error("mag_slice_cmp: SLICE_W must be at least 1");
      end
   endgenerate

   // Scan from the low bit upward. A higher differing bit overwrites
   // any lower decision, so the most significant difference wins.
   always_comb begin
      verdict = ORD_EQ;
      for (int i = 0; i < SLICE_W; i++) begin
         if (a_part[i] != b_part[i]) begin
            verdict.gt = a_part[i];
            verdict.eq = 1'b0;
            verdict.lt = b_part[i];
         end
      end
   end

endmodule

// File: rtl/slice_merge.sv
module slice_merge
   import sm_compare_pkg::*;
#(
   parameter int NUM_SLICES = 2
) (
   input  ord_t [NUM_SLICES-1:0] part,
   output ord_t                  total
);

   generate
      if (NUM_SLICES < 1) begin : g_bad_count
         $error("slice_merge: NUM_SLICES must be at least 1");
      end
   endgenerate

   ord_t [NUM_SLICES-1:0] acc;

   // Slice 0 is least significant. Each stage lets the next slice up
   // override the accumulated verdict unless that slice is equal.
   assign acc[0] = part[0];

   generate
      for (genvar k = 1; k < NUM_SLICES; k++) begin : g_join
         assign acc[k] = ord_join(part[k], acc[k-1]);
      end
   endgenerate

   assign total = acc[NUM_SLICES-1];

endmodule

// File: rtl/sign_resolve.sv
module sign_resolve
   import sm_compare_pkg::*;
(
   input  ord_t mag_ord,
   input  logic a_neg,
   input  logic b_neg,
   input  logic a_zero,
   input  logic b_zero,
   output ord_t signed_ord
);

   logic a_eff_neg;
   logic b_eff_neg;

   // A zero magnitude is treated as positive, so -0 and +0 meet as equal.
   assign a_eff_neg = a_neg & ~a_zero;
   assign b_eff_neg = b_neg & ~b_zero;

   always_comb begin
      unique case ({a_eff_neg, b_eff_neg})
         2'b00: signed_ord = mag_ord;
         2'b11: signed_ord = ord_flip(mag_ord);
         2'b01: signed_ord = '{gt: 1'b1, eq: 1'b0, lt: 1'b0};
         default: signed_ord = '{gt: 1'b0, eq: 1'b0, lt: 1'b1};
      endcase
   end

endmodule

// File: rtl/sm_compare.sv
module sm_compare
   import sm_compare_pkg::*;
#(
   parameter int MAG_W   = 8,
   parameter int SLICE_W = 4
) (
   input  logic [MAG_W-1:0] a_mag,
   input  logic             a_neg,
   input  logic [MAG_W-1:0] b_mag,
   input  logic             b_neg,
   output logic             a_gt_b,
   output logic             a_eq_b,
   output logic             a_lt_b
);

   localparam int NUM_SLICES = (SLICE_W > 0) ? (MAG_W / SLICE_W) : 1;

   generate
      if (SLICE_W < 1 || MAG_W < SLICE_W || (MAG_W % SLICE_W) != 0) begin : g_bad_cfg
         $error("sm_compare: MAG_W must be a positive multiple of SLICE_W");
      end
   endgenerate

   ord_t [NUM_SLICES-1:0] slice_ord;
   ord_t                  mag_ord;
   ord_t                  final_ord;

   generate
      for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
         mag_slice_cmp #(.SLICE_W(SLICE_W)) u_slice (
            .a_part  (a_mag[s*SLICE_W +: SLICE_W]),
            .b_part  (b_mag[s*SLICE_W +: SLICE_W]),
            .verdict (slice_ord[s])
         );
      end
   endgenerate

   slice_merge #(.NUM_SLICES(NUM_SLICES)) u_merge (
      .part  (slice_ord),
      .total (mag_ord)
   );

   sign_resolve u_sign (
      .mag_ord    (mag_ord),
      .a_neg      (a_neg),
      .b_neg      (b_neg),
      .a_zero     (a_mag == '0),
      .b_zero     (b_mag == '0),
      .signed_ord (final_ord)
   );

   assign a_gt_b = final_ord.gt;
   assign a_eq_b = final_ord.eq;
   assign a_lt_b = final_ord.lt;

endmodule

// File: rtl/sm_compare_chk.sv
module sm_compare_chk #(
   parameter int MAG_W = 8
) (
   input logic [MAG_W-1:0] a_mag,
   input logic             a_neg,
   input logic [MAG_W-1:0] b_mag,
   input logic             b_neg,
   input logic             a_gt_b,
   input logic             a_eq_b,
   input logic             a_lt_b
);

   logic known;
   logic a_z;
   logic b_z;

   assign known = !$isunknown({a_mag, a_neg, b_mag, b_neg});
   assign a_z   = (a_mag == '0);
   assign b_z   = (b_mag == '0);

   always_comb begin
      if (known) begin
         // R9
         one_hot_chk: assert ($countones({a_gt_b, a_eq_b, a_lt_b}) == 1)
            else $error("outputs not one-hot");
         // R8
         zero_eq_chk: assert (!(a_z && b_z) || a_eq_b)
            else $error("+0/-0 not equal");
         // R5
         sign_diff_chk: assert (!((a_neg && !a_z) && !(b_neg && !b_z)) || a_lt_b)
            else $error("negative A not below positive B");
         // R6
         pos_order_chk: assert ((a_neg || b_neg) || (a_gt_b == (a_mag > b_mag)))
            else $error("positive ordering wrong");
         // R7
         neg_rev_chk: assert (!(a_neg && b_neg && !a_z && !b_z) || (a_lt_b == (a_mag > b_mag)))
            else $error("negative ordering not reversed");
         // R3
         mag_eq_chk: assert ((a_neg != b_neg) || (a_eq_b == (a_mag == b_mag)))
            else $error("equality wrong");
      end
   end

endmodule

bind sm_compare sm_compare_chk #(.MAG_W(MAG_W)) u_chk (
   .a_mag  (a_mag),
   .a_neg  (a_neg),
   .b_mag  (b_mag),
   .b_neg  (b_neg),
   .a_gt_b (a_gt_b),
   .a_eq_b (a_eq_b),
   .a_lt_b (a_lt_b)
);

// File: tb/sm_compare_test.sv
module sm_compare_test;

   localparam int MAG_W = 8;
   localparam int WATCHDOG_CYCLES = 150000;

   logic             clk = 1'b0;
   logic [MAG_W-1:0] a_mag = '0;
   logic             a_neg = 1'b0;
   logic [MAG_W-1:0] b_mag = '0;
   logic             b_neg = 1'b0;
   logic             a_gt_b, a_eq_b, a_lt_b;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   sm_compare #(.MAG_W(MAG_W), .SLICE_W(4)) uut (
      .a_mag  (a_mag),
      .a_neg  (a_neg),
      .b_mag  (b_mag),
      .b_neg  (b_neg),
      .a_gt_b (a_gt_b),
      .a_eq_b (a_eq_b),
      .a_lt_b (a_lt_b)
   );

   task automatic apply(input int am, input bit an, input int bm, input bit bn);
      a_mag = am[MAG_W-1:0];
      a_neg = an;
      b_mag = bm[MAG_W-1:0];
      b_neg = bn;
      #1;
   endtask

   // Expected outputs from signed integer values; zero is sign-free.
   task automatic check(input string req);
      int va, vb;
      logic [2:0] exp, got;
      va = a_neg ? -int'(a_mag) : int'(a_mag);
      vb = b_neg ? -int'(b_mag) : int'(b_mag);
      exp = {va > vb, va == vb, va < vb};
      got = {a_gt_b, a_eq_b, a_lt_b};
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: a=%s%0d b=%s%0d got gt/eq/lt=%b expected %b",
                  req, a_neg ? "-" : "+", a_mag, b_neg ? "-" : "+", b_mag, got, exp);
      end
      checks++;
      if ($countones(got) != 1) begin
         fails++;
         $display("FAIL R9: a=%0d b=%0d got gt/eq/lt=%b expected exactly one bit",
                  a_mag, b_mag, got);
      end
   endtask

   initial begin
      // Quiescent state with all inputs zero: equal.
      apply(0, 0, 0, 0);   check("R8");
      // R1: highest differing bit wins inside a slice
      apply(8'h08, 0, 8'h07, 0); check("R1");
      apply(8'h01, 0, 8'h02, 0); check("R1");
      // R2: high slice decides, then low slice
      apply(8'h80, 0, 8'h7F, 0); check("R2");
      apply(8'h36, 0, 8'h35, 0); check("R2");
      // R3: equality needs every slice equal
      apply(8'h35, 0, 8'h35, 0); check("R3");
      apply(8'h35, 0, 8'h25, 0); check("R3");
      apply(8'h35, 1, 8'h35, 1); check("R3");
      // R4: less via high slice or via low slice
      apply(8'h34, 0, 8'h35, 0); check("R4");
      apply(8'h0F, 0, 8'h10, 0); check("R4");
      // R5: differing signs
      apply(8'h01, 0, 8'hFF, 1); check("R5");
      apply(8'hFF, 1, 8'h01, 0); check("R5");
      // R7: reversed ordering for negatives
      apply(8'h80, 1, 8'h7F, 1); check("R7");
      // R8: signed zeros
      apply(0, 1, 0, 0); check("R8");
      apply(0, 1, 8'h05, 1); check("R8");
      apply(8'h05, 1, 0, 1); check("R8");

      // Exhaustive sweep over magnitudes and sign pairs.
      for (int sg = 0; sg < 4; sg++) begin
         for (int am = 0; am < (1 << MAG_W); am++) begin
            for (int bm = 0; bm < (1 << MAG_W); bm++) begin
               apply(am, sg[1], bm, sg[0]);
               if (am == 0 || bm == 0)  check("R8");
               else if (sg == 1 || sg == 2) check("R5");
               else if (sg == 3)        check("R7");
               else                     check("R6");
            end
         end
      end
      done = 1'b1;
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
   end

   initial begin
      wait (done || cycles >= WATCHDOG_CYCLES);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run hung after %0d cycles, expected completion", cycles);
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule